// File: doc/BRIEF.md
# Buffered Four-Channel Input Capture

This block is a timer capture unit. It is built around a 16-bit counter that runs on every clock. Four capture channels, numbered 0 to 3, each watch one input pin. When a channel's pin makes the chosen transition, the channel records the counter value and raises its flag. Software, or a neighbouring block, reads the four held values and the flag vector, and drops flags with a per-channel clear pulse.

Channels 0 and 2 can work as a pair. When pairing is on, channel 2 becomes a history register for channel 0. Each capture on pin 0 pushes the previous channel-0 value into channel 2 and loads the fresh count into channel 0. This gives the two most recent edge times on pin 0 with no software copy in between.

Top module: `icap_quad`

## Requirements
- R1: While reset is asserted, all four capture values and all four flags are zero, and the counter is zero.
- R2: The counter advances by one on every clock. It wraps from 0xFFFF to 0x0000, and it returns to 0 on the clock edge where `cntClear` is high. A capture on that same edge records the count from before the clear.
- R3: A pin change applied before clock edge k is captured at edge k+2, because of a two-flop synchronizer and a one-flop edge detector. The value stored is the count held just before edge k+2, which is the count at the time of the change plus 2.
- R4: `edgeRise[i]` = 1 selects a low-to-high transition on pin i, and 0 selects high-to-low. A transition in the other direction changes neither the capture value nor the flag of that channel.
- R5: Flag i (bit i of `capFlags`) becomes 1 on the same clock edge on which capture value i is loaded.
- R6: A capture takes place even when the channel's flag is already 1.
- R7: A high `flagClr[i]` clears flag i on the next edge. If a capture on channel i happens on that same edge, the flag stays 1.
- R8: With `pairAC` = 1, a capture on pin 0 moves the old channel-0 value into channel 2 and loads the count into channel 0, both on the same edge.
- R9: With `pairAC` = 1, an edge on pin 2 does not load channel 2 from the counter. It still sets flag 2. Channel 2 changes only through the move from channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| capPin | input | 4 | Capture input pins, bit i for channel i |
| edgeRise | input | 4 | Per-channel edge select: 1 for rising, 0 for falling |
| pairAC | input | 1 | Makes channel 2 the history register for channel 0 |
| cntClear | input | 1 | Returns the counter to zero |
| flagClr | input | 4 | Per-channel flag clear pulse |
| capValA | output | 16 | Capture value, channel 0 |
| capValB | output | 16 | Capture value, channel 1 |
| capValC | output | 16 | Capture value, channel 2 |
| capValD | output | 16 | Capture value, channel 3 |
| capFlags | output | 4 | Capture flags, bit i for channel i |

## Verification
Two operations can land on the same clock edge: a capture that sets a flag, and a clear pulse aimed at that same flag. A second collision is a capture that falls on the edge where the counter is cleared. Both are forced with directed timing. The pin is raised two edges ahead, so the clear pulse lands exactly on the capture edge, and random traffic also produces them. A bench model decides the outcome: the capture wins the flag, and the stored value is the count from before the clear.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int CH_N  = 4;
  localparam int CNT_W = 16;
  localparam int CH_A  = 0;   // channel that feeds the history register
  localparam int CH_C  = 2;   // history register when paired
  localparam int SYNC_W = 3;  // two synchronizer flops plus one history flop

  typedef struct packed {
    logic [CH_N-1:0] edgeHit;   // qualified edge seen on pin
    logic [CH_N-1:0] loadCnt;   // load counter into channel
    logic            moveAtoC;  // shift channel A into channel C
  } icapStb_t;
endpackage

// File: rtl/icap_ctrl.sv
module icap_ctrl
  import icap_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_N-1:0] pinIn,
  input  logic [CH_N-1:0] edgeRise,
  input  logic            pairAC,
  input  logic [CH_N-1:0] flagClr,
  output icapStb_t        stb,
  output logic [CH_N-1:0] flags
);
  localparam logic [CH_N-1:0] C_MASK = CH_N'(1) << CH_C;

  logic [CH_N-1:0] hit;

  for (genvar g = 0; g < CH_N; g++) begin : gSync
    logic [SYNC_W-1:0] syncQ;
    logic riseSeen, fallSeen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_W-2:0], pinIn[g]};
    end

    assign riseSeen = syncQ[SYNC_W-2] & ~syncQ[SYNC_W-1];
    assign fallSeen = ~syncQ[SYNC_W-2] & syncQ[SYNC_W-1];
    assign hit[g]   = edgeRise[g] ? riseSeen : fallSeen;
  end

  always_comb begin
    stb.edgeHit  = hit;
    stb.loadCnt  = hit & ~(pairAC ? C_MASK : '0);
    stb.moveAtoC = pairAC & hit[CH_A];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~flagClr) | hit;
  end
endmodule

// File: rtl/icap_dpath.sv
module icap_dpath
  import icap_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntClear,
  input  icapStb_t     stb,
  output logic [W-1:0] countVal,
  output logic [W-1:0] capQ [CH_N]
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         countVal <= '0;
    else if (cntClear) countVal <= '0;
    else               countVal <= countVal + W'(1);
  end

  for (genvar g = 0; g < CH_N; g++) begin : gCap
    if (g == CH_C) begin : gHist
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                capQ[g] <= '0;
        else if (stb.moveAtoC)    capQ[g] <= capQ[CH_A];
        else if (stb.loadCnt[g])  capQ[g] <= countVal;
      end
    end else begin : gPlain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               capQ[g] <= '0;
        else if (stb.loadCnt[g]) capQ[g] <= countVal;
      end
    end
  end
endmodule

// File: rtl/icap_quad.sv
module icap_quad
  import icap_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   capPin,
  input  logic [3:0]   edgeRise,
  input  logic         pairAC,
  input  logic         cntClear,
  input  logic [3:0]   flagClr,
  output logic [W-1:0] capValA,
  output logic [W-1:0] capValB,
  output logic [W-1:0] capValC,
  output logic [W-1:0] capValD,
  output logic [3:0]   capFlags
);
  icapStb_t     stb;
  logic [W-1:0] countVal;
  logic [W-1:0] capQ [CH_N];

  icap_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (capPin),
    .edgeRise(edgeRise),
    .pairAC  (pairAC),
    .flagClr (flagClr),
    .stb     (stb),
    .flags   (capFlags)
  );

  icap_dpath #(.W(W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .cntClear(cntClear),
    .stb     (stb),
    .countVal(countVal),
    .capQ    (capQ)
  );

  assign capValA = capQ[0];
  assign capValB = capQ[1];
  assign capValC = capQ[2];
  assign capValD = capQ[3];
endmodule

// File: rtl/icap_quad_chk.sv
module icap_quad_chk
  import icap_pkg::*;
#(
  parameter int W = CNT_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            cntClear,
  input logic            pairAC,
  input logic [CH_N-1:0] flagClr,
  input icapStb_t        stb,
  input logic [W-1:0]    countVal,
  input logic [CH_N-1:0] flags,
  input logic [W-1:0]    capA,
  input logic [W-1:0]    capC
);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cntClear |=> countVal == $past(countVal) + W'(1));

  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> countVal == '0);

  p_load_a_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt[CH_A] |=> capA == $past(countVal));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.edgeHit) |=> (flags & $past(stb.edgeHit)) == $past(stb.edgeHit));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagClr & ~stb.edgeHit)) |=> (flags & $past(flagClr & ~stb.edgeHit)) == '0);

  p_buffer_move_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.moveAtoC |=> capC == $past(capA));

  p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pairAC && !stb.moveAtoC) |=> $stable(capC));
endmodule

bind icap_quad icap_quad_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cntClear(cntClear),
  .pairAC  (pairAC),
  .flagClr (flagClr),
  .stb     (stb),
  .countVal(countVal),
  .flags   (capFlags),
  .capA    (capValA),
  .capC    (capValC)
);

// File: tb/tb_icap_quad.sv
module tb_icap_quad;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  capPin = '0, edgeRise = 4'hF, flagClr = '0;
  logic        pairAC = 1'b0, cntClear = 1'b0;
  logic [15:0] capValA, capValB, capValC, capValD;
  logic [3:0]  capFlags;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  // reference model state
  logic [15:0] mCap [4];
  logic [15:0] mCnt;
  logic [3:0]  mFlags, mS1, mS2, mS3;

  icap_quad dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] hitOf(logic [3:0] s2, logic [3:0] s3, logic [3:0] eR);
    return ((s2 & ~s3) & eR) | ((~s2 & s3) & ~eR);
  endfunction

  task automatic compareAll();
    chk(phase, "capValA", capValA, mCap[0]);
    chk(phase, "capValB", capValB, mCap[1]);
    chk(phase, "capValC", capValC, mCap[2]);
    chk(phase, "capValD", capValD, mCap[3]);
    chk(phase, "capFlags", {12'd0, capFlags}, {12'd0, mFlags});
  endtask

  task automatic step();
    logic [3:0]  hit;
    logic [15:0] oldA;
    @(posedge clk);
    #2;
    hit  = hitOf(mS2, mS3, edgeRise);
    oldA = mCap[0];
    if (hit[0]) begin
      if (pairAC) mCap[2] = oldA;
      mCap[0] = mCnt;
    end
    if (hit[1]) mCap[1] = mCnt;
    if (hit[2] && !pairAC) mCap[2] = mCnt;
    if (hit[3]) mCap[3] = mCnt;
    mFlags = (mFlags & ~flagClr) | hit;
    mS3 = mS2; mS2 = mS1; mS1 = capPin;
    mCnt = cntClear ? 16'd0 : mCnt + 16'd1;
    compareAll();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [15:0] expV, prevA;
    int unsigned r;
    r = $urandom(32'h1C4B);
    for (int i = 0; i < 4; i++) mCap[i] = '0;
    mCnt = '0; mFlags = '0; mS1 = '0; mS2 = '0; mS3 = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    compareAll();
    rstN = 1'b1;
    steps(4);

    // R3: latency and captured value
    phase = "R3";
    capPin[0] = 1'b1;
    expV = mCnt + 16'd2;
    steps(3);
    chk("R3", "capValA latency", capValA, expV);
    chk("R5", "flag0", {15'd0, capFlags[0]}, 16'd1);

    // R4: falling select ignores rising edge
    phase = "R4";
    edgeRise[1] = 1'b0;
    steps(3);
    capPin[1] = 1'b1;
    steps(4);
    chk("R4", "capValB on wrong edge", capValB, 16'd0);
    chk("R4", "flag1 on wrong edge", {15'd0, capFlags[1]}, 16'd0);
    capPin[1] = 1'b0;
    expV = mCnt + 16'd2;
    steps(3);
    chk("R4", "capValB falling", capValB, expV);

    // R6: capture with flag already set
    phase = "R6";
    capPin[0] = 1'b0;
    steps(3);
    capPin[0] = 1'b1;
    expV = mCnt + 16'd2;
    steps(3);
    chk("R6", "capValA with flag set", capValA, expV);

    // R7: clear alone, then clear colliding with capture
    phase = "R7";
    flagClr = 4'b0010;
    step();
    flagClr = '0;
    step();
    chk("R7", "flag1 cleared", {15'd0, capFlags[1]}, 16'd0);
    capPin[3] = 1'b1;
    steps(2);
    flagClr = 4'b1000;
    step();
    flagClr = '0;
    chk("R7", "flag3 capture wins", {15'd0, capFlags[3]}, 16'd1);

    // R8: buffered pair
    phase = "R8";
    pairAC = 1'b1;
    capPin[0] = 1'b0;
    steps(3);
    prevA = capValA;
    capPin[0] = 1'b1;
    expV = mCnt + 16'd2;
    steps(3);
    chk("R8", "capValC gets old A", capValC, prevA);
    chk("R8", "capValA new", capValA, expV);

    // R9: pin C ignored for the value while paired
    phase = "R9";
    prevA = capValC;
    flagClr = 4'b0100;
    step();
    flagClr = '0;
    capPin[2] = 1'b1;
    steps(4);
    chk("R9", "capValC held", capValC, prevA);
    chk("R9", "flag2 set", {15'd0, capFlags[2]}, 16'd1);

    // random traffic, also provokes capture/clear collisions
    phase = "R5";
    for (int i = 0; i < 3000; i++) begin
      capPin   = capPin ^ (4'($urandom) & 4'($urandom));
      flagClr  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      cntClear = ($urandom % 64) == 0;
      if (($urandom % 50) == 0) edgeRise = 4'($urandom);
      if (($urandom % 80) == 0) pairAC = ~pairAC;
      step();
    end

    // R2: wrap of the counter, and clear with capture
    phase = "R2";
    capPin = '0; flagClr = '0; pairAC = 1'b0; edgeRise = 4'hF; cntClear = 1'b1;
    step();
    cntClear = 1'b0;
    chk("R2", "count after clear via model", mCnt, 16'd0);
    while (mCnt != 16'hFFFC) step();
    capPin[0] = 1'b1;
    step();
    capPin[1] = 1'b1;
    step();
    capPin[3] = 1'b1;
    steps(4);
    chk("R2", "capValA before wrap", capValA, 16'hFFFE);
    chk("R2", "capValB at top", capValB, 16'hFFFF);
    chk("R2", "capValD after wrap", capValD, 16'h0000);
    capPin[1] = 1'b0; edgeRise[1] = 1'b0;
    steps(2);
    expV = mCnt;
    cntClear = 1'b1;
    step();
    cntClear = 1'b0;
    chk("R2", "capValB on clear edge", capValB, expV);
    summary();
  end
endmodule